// File: doc/BRIEF.md
# SPI status and mode controller

This block keeps the mode and error state of an SPI controller: an enable bit that moves the controller between configuration mode (enable clear) and operational mode (enable set), a master-select bit, and six sticky error flags. These are mode error, TX overflow, RX overflow, abort, TX underflow and RX underflow. It also passes a busy indication from the shift core through to its status word.

Software never writes the status word directly. It writes a 16-bit command word that has one set bit and one clear bit for each stored bit. A 1 in a command bit acts on its flag, and a 0 has no effect. The shift core and the FIFOs report errors as single-cycle event pulses. Five enable bits from the control register decide which of those events are recorded. Whenever any error flag is set, a level interrupt is raised.

Top module: `spi_stat_ctl`

## Requirements
- R1: After a synchronous active-low reset, status bits 0 to 12 are 0 and the error interrupt is low.
- R2: Status word layout: enable at bit 0, master-select at bit 1, mode error at 7, TX overflow at 8, RX overflow at 9, abort at 10, TX underflow at 11, RX underflow at 12, busy at 13. Bits 2 to 6, 14 and 15 read 0.
- R3: A command write takes effect on the status word one clock after it is accepted. The command bit positions are: clear/set enable 0/1, clear/set master-select 2/3, clear/set RX underflow 4/5, clear/set mode error 6/7, clear TX overflow/RX overflow/abort/TX underflow 8/9/10/11, and set TX overflow/RX overflow/abort/TX underflow 12/13/14/15.
- R4: Command bits written as 0 change nothing, and command data presented with the write strobe low changes nothing.
- R5: When one write both sets and clears the same flag, the flag ends up cleared.
- R6: Error event inputs use the order {RX underflow, TX underflow, abort, RX overflow, TX overflow, mode error}, bit 5 down to bit 0. An event on bits 1 to 5 sets its flag only when the matching enable input bit is 1. The enable input is indexed 12 down to 8, at the same position as the flag's status bit. A mode-error event is always recorded.
- R7: An error flag stays set after its event ends, until software clears it.
- R8: A recorded hardware event in the same cycle as a software clear of that flag leaves the flag set.
- R9: The error interrupt is high in exactly the cycles when at least one of the six error flags is set. Enable and master-select do not raise it.
- R10: Status bit 13 follows the busy input in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 16 | Set/clear command word |
| err_en_i | input | 5 | Error capture enables, indexed [12:8] |
| err_evt_i | input | 6 | Error event pulses |
| busy_i | input | 1 | Busy indication from the shift core |
| stat_o | output | 16 | Status word |
| err_irq_o | output | 1 | Level error interrupt |

## Verification
Stored bits respond to a command or an event at the clock edge that samples it, so each result is due one edge after the stimulus. The busy bit and the interrupt follow their sources in the same cycle. The driver applies each stimulus at a falling edge and queues the expected status for the next rising edge. The monitor compares the outputs 1 ns after that rising edge, so every check samples both the updated registers and the busy input held since the falling edge.

// File: rtl/spi_stat_pkg.sv
// Shared constants for the SPI status and mode controller.
// Flag index order: 0 enable, 1 master-select, 2..7 the six error flags
// (mode, TX overflow, RX overflow, abort, TX underflow, RX underflow).
package spi_stat_pkg;
    localparam int unsigned NUM_ERR   = 6;
    localparam int unsigned NUM_FLAGS = NUM_ERR + 2;
    localparam int unsigned FIRST_ERR = 2;
    localparam int unsigned BUSY_POS  = 13;
    // Status word bit for each flag.
    localparam int unsigned STAT_POS [NUM_FLAGS] = '{0, 1, 7, 8, 9, 10, 11, 12};
    // Command bit that sets each flag.
    localparam int unsigned SET_POS  [NUM_FLAGS] = '{1, 3, 7, 12, 13, 14, 15, 5};
    // Command bit that clears each flag.
    localparam int unsigned CLR_POS  [NUM_FLAGS] = '{0, 2, 6, 8, 9, 10, 11, 4};
endpackage

// File: rtl/ssm_cmd_decode.sv
// Turns an accepted command write into per-flag set and clear strobes.
// Assumes the command positions in spi_stat_pkg fit inside CMD_W.
module ssm_cmd_decode
    import spi_stat_pkg::*;
#(
    parameter int CMD_W = 16
) (
    input  logic                 we_i,
    input  logic [CMD_W-1:0]     cmd_i,
    output logic [NUM_FLAGS-1:0] set_o,
    output logic [NUM_FLAGS-1:0] clr_o
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
        // Strobe only when written with a 1 under the write enable.
        assign set_o[i] = we_i & cmd_i[SET_POS[i]];
        assign clr_o[i] = we_i & cmd_i[CLR_POS[i]];
    end
endmodule

// File: rtl/ssm_err_gate.sv
// Gates the error event pulses with their capture enables.
// Enable and master-select get no hardware event. The mode error is ungated.
// The enable vector is indexed by the status bit of its flag.
module ssm_err_gate
    import spi_stat_pkg::*;
#(
    parameter int EN_LO = 8,
    parameter int EN_HI = 12
) (
    input  logic [EN_HI:EN_LO]   en_i,
    input  logic [NUM_ERR-1:0]   evt_i,
    output logic [NUM_FLAGS-1:0] hw_o
);
    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_gate
        if (i < FIRST_ERR) begin : g_none
            // Mode bits are software-only.
            assign hw_o[i] = 1'b0;
        end else if (STAT_POS[i] < EN_LO) begin : g_free
            // No enable exists for this error: always captured.
            assign hw_o[i] = evt_i[i-FIRST_ERR];
        end else begin : g_en
            // Captured only with its enable set.
            assign hw_o[i] = evt_i[i-FIRST_ERR] & en_i[STAT_POS[i]];
        end
    end
endmodule

// File: rtl/ssm_flag_cell.sv
// One stored status bit. A software clear beats a software set.
// A hardware event beats a software clear.
// Assumes a synchronous active-low reset to 0.
module ssm_flag_cell (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    input  logic hw_i,
    output logic q_o
);
    // Update the bit with the priority hardware > clear > set > hold.
    always_ff @(posedge clk) begin
        if (!rst_n) q_o <= 1'b0;
        else        q_o <= hw_i | ((q_o | set_i) & ~clr_i);
    end
endmodule

// File: rtl/spi_stat_ctl.sv
// Top level of the SPI status and mode controller: decodes commands, gates
// error events, stores the flags and assembles the status word and interrupt.
// Assumes error events are pulses synchronous to clk.
module spi_stat_ctl
    import spi_stat_pkg::*;
#(
    parameter int CMD_W  = 16,
    parameter int STAT_W = 16,
    parameter int EN_LO  = 8,
    parameter int EN_HI  = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cmd_we_i,
    input  logic [CMD_W-1:0]     cmd_i,
    input  logic [EN_HI:EN_LO]   err_en_i,
    input  logic [NUM_ERR-1:0]   err_evt_i,
    input  logic                 busy_i,
    output logic [STAT_W-1:0]    stat_o,
    output logic                 err_irq_o
);
    logic [NUM_FLAGS-1:0] set_v, clr_v, hw_v, flag_q;

    ssm_cmd_decode #(.CMD_W(CMD_W)) u_dec (
        .we_i (cmd_we_i),
        .cmd_i(cmd_i),
        .set_o(set_v),
        .clr_o(clr_v)
    );

    ssm_err_gate #(.EN_LO(EN_LO), .EN_HI(EN_HI)) u_gate (
        .en_i (err_en_i),
        .evt_i(err_evt_i),
        .hw_o (hw_v)
    );

    for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
        ssm_flag_cell u_cell (
            .clk  (clk),
            .rst_n(rst_n),
            .set_i(set_v[i]),
            .clr_i(clr_v[i]),
            .hw_i (hw_v[i]),
            .q_o  (flag_q[i])
        );
    end

    // Place each stored flag and the busy input at its status position.
    always_comb begin
        stat_o = '0;
        for (int i = 0; i < NUM_FLAGS; i++) stat_o[STAT_POS[i]] = flag_q[i];
        stat_o[BUSY_POS] = busy_i;
    end

    // Level interrupt from any stored error flag.
    assign err_irq_o = |flag_q[NUM_FLAGS-1:FIRST_ERR];
endmodule

// File: rtl/spi_stat_ctl_chk.sv
// Property checker for spi_stat_ctl, attached with bind. It observes ports only.
module spi_stat_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_we_i,
    input logic [15:0] cmd_i,
    input logic [12:8] err_en_i,
    input logic [5:0]  err_evt_i,
    input logic        busy_i,
    input logic [15:0] stat_o,
    input logic        err_irq_o
);
    // R1: reset leaves every stored bit clear and the interrupt low.
    p_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (stat_o[12:0] == 13'd0 && !err_irq_o));

    // R4: no write and no event keeps the stored bits unchanged.
    p_ignore_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_we_i && err_evt_i == 6'd0) |=> $stable(stat_o[12:0]));

    // R5: a write that sets and clears enable leaves it cleared.
    p_clr_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we_i && cmd_i[0] && cmd_i[1]) |=> !stat_o[0]);

    // R6: a TX overflow event with its enable low is not recorded.
    p_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!stat_o[8] && !err_en_i[8] && !(cmd_we_i && cmd_i[12])) |=> !stat_o[8]);

    // R7: the TX overflow flag holds until it is cleared.
    p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o[8] && !(cmd_we_i && cmd_i[8])) |=> stat_o[8]);

    // R8: an enabled event is recorded even against a clear.
    p_evt_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (err_evt_i[1] && err_en_i[8]) |=> stat_o[8]);

    // R9: the interrupt matches the error flags in the status word.
    p_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        err_irq_o == (stat_o[12:7] != 6'd0));

    // R10: the busy bit follows its input.
    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        stat_o[13] == busy_i);
endmodule

bind spi_stat_ctl spi_stat_ctl_chk u_chk (.*);

// File: tb/sim_spi_stat_ctl.sv
`timescale 1ns/1ps
module sim_spi_stat_ctl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_we_i = 1'b0;
    logic [15:0] cmd_i = '0;
    logic [12:8] err_en_i = '0;
    logic [5:0]  err_evt_i = '0;
    logic        busy_i = 1'b0;
    logic [15:0] stat_o;
    logic        err_irq_o;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [15:0] stat;
        logic        irq;
        string       tag;
    } exp_t;
    exp_t sb[$];

    // Reference state, kept from the requirements.
    logic       m_en = 1'b0, m_ms = 1'b0;
    logic [5:0] m_err = '0;

    always #2.5 clk = ~clk;

    spi_stat_ctl u0 (
        .clk(clk), .rst_n(rst_n), .cmd_we_i(cmd_we_i), .cmd_i(cmd_i),
        .err_en_i(err_en_i), .err_evt_i(err_evt_i), .busy_i(busy_i),
        .stat_o(stat_o), .err_irq_o(err_irq_o)
    );

    task automatic compare(input exp_t e);
        checks++;
        if (stat_o !== e.stat || err_irq_o !== e.irq) begin
            errors++;
            $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                     e.tag, stat_o, err_irq_o, e.stat, e.irq);
        end
    endtask

    // Driver: apply one cycle of stimulus and queue the expected result.
    task automatic step(input logic we, input logic [15:0] cmd,
                        input logic [12:8] en, input logic [5:0] evt,
                        input logic busy, input string tag);
        logic [15:0] s, c;
        exp_t e;
        @(negedge clk);
        cmd_we_i = we; cmd_i = cmd; err_en_i = en; err_evt_i = evt; busy_i = busy;
        s = we ? cmd : 16'h0;
        c = we ? cmd : 16'h0;
        m_en = (m_en | s[1]) & ~c[0];
        m_ms = (m_ms | s[3]) & ~c[2];
        begin
            logic [5:0] sv, cv, hv;
            sv = {s[5], s[15], s[14], s[13], s[12], s[7]};
            cv = {c[4], c[11], c[10], c[9], c[8], c[6]};
            hv = evt & {en[12], en[11], en[10], en[9], en[8], 1'b1};
            m_err = hv | ((m_err | sv) & ~cv);
        end
        e.stat = 16'h0;
        e.stat[0] = m_en;
        e.stat[1] = m_ms;
        e.stat[12:7] = m_err;
        e.stat[13] = busy;
        e.irq = |m_err;
        e.tag = tag;
        sb.push_back(e);
    endtask

    // Monitor: compare just after each rising edge.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (sb.size() > 0) compare(sb.pop_front());
        end
    end

    // Watchdog.
    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not end, expected end before 5000 cycles");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #1;
        r.stat = 16'h0; r.irq = 1'b0; r.tag = "R1 reset";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        step(0, 16'h0000, 5'h00, 6'h00, 0, "R1 idle after reset");
        step(1, 16'h0002, 5'h00, 6'h00, 0, "R3 set enable");
        step(1, 16'h0008, 5'h00, 6'h00, 0, "R3 set master-select");
        step(1, 16'h0000, 5'h00, 6'h00, 0, "R4 zero command bits");
        step(0, 16'hFFFF, 5'h00, 6'h00, 0, "R4 data without strobe");
        step(1, 16'h0003, 5'h00, 6'h00, 0, "R5 enable set and clear");
        step(1, 16'hF0A0, 5'h00, 6'h00, 0, "R2 R9 set all errors by command");
        step(1, 16'h0F50, 5'h00, 6'h00, 0, "R3 clear all errors by command");
        step(1, 16'h1100, 5'h00, 6'h00, 0, "R5 TX overflow set and clear");
        step(0, 16'h0000, 5'h00, 6'h02, 0, "R6 TX overflow event gated off");
        step(0, 16'h0000, 5'h01, 6'h02, 0, "R6 TX overflow event enabled");
        step(0, 16'h0000, 5'h01, 6'h00, 0, "R7 flag held after event");
        step(1, 16'h0100, 5'h01, 6'h02, 0, "R8 event against clear");
        step(1, 16'h0100, 5'h01, 6'h00, 0, "R3 clear TX overflow");
        step(0, 16'h0000, 5'h00, 6'h01, 0, "R6 mode error ungated");
        step(0, 16'h0000, 5'h1F, 6'h3F, 0, "R6 all events enabled");
        step(0, 16'h0000, 5'h00, 6'h00, 0, "R7 all flags held");
        step(1, 16'h0F50, 5'h00, 6'h00, 0, "R9 clear all, interrupt drops");
        step(0, 16'h0000, 5'h00, 6'h00, 1, "R10 busy high");
        step(1, 16'h000A, 5'h00, 6'h00, 1, "R9 mode bits raise no interrupt");
        step(0, 16'h0000, 5'h10, 6'h3E, 0, "R6 only RX underflow enabled");
        step(1, 16'h0015, 5'h00, 6'h00, 0, "R3 clear enable, master-select, RX underflow");
        step(0, 16'h0000, 5'h00, 6'h00, 0, "R4 final idle");
        repeat (3) @(posedge clk);
        #2;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule